// File: doc/BRIEF.md
# Hamming-Distance Output Lock

This block protects a single output bit of a combinational function. A W-bit slice of the signals that feed that output is compared against two keys. One key is fixed when the block is elaborated. The other key arrives on an input at run time. Each comparison path XORs the slice with its key and counts the ones in the result. The path fires only when that count equals a fixed distance HD. The protected bit is the original bit XOR both path outputs.

With the wrong run-time key, the output is inverted for exactly those slice values that sit at distance HD from one key but not from the other. With the correct key, the two paths always agree, their effects cancel, and the protected bit equals the original bit for every slice value. With HD set to zero, each path fires only on an exact match between slice and key, so the block becomes a plain equality lock.

The block is purely combinational. It has no clock, no reset and no storage. A parameter selects how the ones are counted: a balanced adder tree or a linear accumulation chain.

Top module: `hdlock_unit`

## Requirements
- R1: The fixed-key path fires exactly when the number of ones in (slice_i XOR FIX_KEY) equals HD.
- R2: The run-time path fires exactly when the number of ones in (slice_i XOR key_i) equals HD.
- R3: prot_o equals func_i XOR fixed-path hit XOR run-time-path hit, with no clock delay.
- R4: When key_i equals FIX_KEY, prot_o equals func_i for every slice_i value and for both values of func_i.
- R5: For a wrong key, the number of slice values that invert prot_o equals the number of slice values at distance HD from exactly one of FIX_KEY and key_i.
- R6: With HD = 0, prot_o is inverted only when slice_i equals exactly one of FIX_KEY and key_i.
- R7: The ones count is carried in clog2(W)+1 bits, never exceeds W, and an HD outside 0..W is rejected at elaboration.
- R8: The adder-tree counter (CNT_STYLE = 0) and the chain counter (CNT_STYLE = 1) give identical prot_o for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slice_i | input | W | Watched signals taken from the cone of the protected output |
| key_i | input | W | Run-time key |
| func_i | input | 1 | Unprotected output value of the function |
| prot_o | output | 1 | Protected output value |

## Verification
A wrong count in either path shows up at once on prot_o, because there is no register between the inputs and the output. The same input pattern then inverts the output where it should not, or fails to invert it where it should. A bad count typically shows up only for the few slice values near distance HD. For that reason the sweeps cover all 256 slice values for each key. They compare prot_o both per pattern and as a total number of inverted patterns, so that a counter fault shifting which patterns fire is visible even when the totals happen to match. A fault that breaks the cancellation is caught by the sweep with the correct key, where every single pattern must pass through unchanged.

// File: rtl/hdlock_pkg.sv
package hdlock_pkg;

   // counter implementation selector
   typedef enum int {
      CNT_TREE  = 0,
      CNT_CHAIN = 1
   } cnt_style_e;

   // width of a ones count for a W-bit vector: clog2(W)+1 bits
   function automatic int cnt_width(input int w);
      return $clog2(w) + 1;
   endfunction

endpackage

// File: rtl/hdlock_popcnt.sv
module hdlock_popcnt
   import hdlock_pkg::*;
#(
   parameter int W         = 8,
   parameter int CNT_STYLE = CNT_TREE,
   localparam int CW       = cnt_width(W)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   localparam int LVLS = $clog2(W);
   localparam int PADW = 1 << LVLS;

   if (W < 1) begin : g_bad_w
      $error("hdlock_popcnt: W must be at least 1");
   end

   if (CNT_STYLE == CNT_TREE) begin : g_tree
      for (genvar l = 0; l <= LVLS; l++) begin : g_lv
         logic [CW-1:0] s [PADW >> l];
         if (l == 0) begin : g_leaf
            for (genvar i = 0; i < PADW; i++) begin : g_bit
               if (i < W) begin : g_real
                  assign s[i] = CW'(vec_i[i]);
               end else begin : g_pad
                  assign s[i] = '0;
               end
            end
         end else begin : g_sum
            for (genvar i = 0; i < (PADW >> l); i++) begin : g_node
               assign s[i] = g_lv[l-1].s[2*i] + g_lv[l-1].s[2*i+1];
            end
         end
      end
      assign cnt_o = g_lv[LVLS].s[0];
   end else begin : g_chain
      logic [CW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int i = 0; i < W; i++) begin
            acc = acc + CW'(vec_i[i]);
         end
      end
      assign cnt_o = acc;
   end

   always_comb begin
      // R7
      cnt_range_chk: assert (int'(cnt_o) <= W)
         else $error("ones count above vector width");
   end

endmodule

// File: rtl/hdlock_distcmp.sv
module hdlock_distcmp #(
   parameter int CW = 4,
   parameter int HD = 2
) (
   input  logic [CW-1:0] cnt_i,
   output logic          hit_o
);

   localparam logic [CW-1:0] HDV = CW'(HD);

   logic [CW-1:0] diff;

   for (genvar b = 0; b < CW; b++) begin : g_bit
      assign diff[b] = cnt_i[b] ^ HDV[b];
   end

   assign hit_o = ~|diff;

endmodule

// File: rtl/hdlock_path.sv
module hdlock_path
   import hdlock_pkg::*;
#(
   parameter int W         = 8,
   parameter int HD        = 2,
   parameter int CNT_STYLE = CNT_TREE
) (
   input  logic [W-1:0] slice_i,
   input  logic [W-1:0] key_i,
   output logic         hit_o
);

   localparam int CW = cnt_width(W);

   logic [W-1:0]  mix;
   logic [CW-1:0] cnt;

   assign mix = slice_i ^ key_i;

   hdlock_popcnt #(.W(W), .CNT_STYLE(CNT_STYLE)) u_cnt (
      .vec_i (mix),
      .cnt_o (cnt)
   );

   hdlock_distcmp #(.CW(CW), .HD(HD)) u_cmp (
      .cnt_i (cnt),
      .hit_o (hit_o)
   );

   always_comb begin
      // R1 R2
      path_hit_chk: assert (hit_o == ($countones(slice_i ^ key_i) == HD))
         else $error("path hit disagrees with distance");
   end

endmodule

// File: rtl/hdlock_unit.sv
module hdlock_unit
   import hdlock_pkg::*;
#(
   parameter int          W         = 8,
   parameter int          HD        = 2,
   parameter int          CNT_STYLE = CNT_TREE,
   parameter logic [W-1:0] FIX_KEY  = W'(8'hB2)
) (
   input  logic [W-1:0] slice_i,
   input  logic [W-1:0] key_i,
   input  logic         func_i,
   output logic         prot_o
);

   // R7 elaboration-time parameter checks
   if (HD < 0 || HD > W) begin : g_bad_hd
      $error("hdlock_unit: HD must lie in 0..W");
   end
   if (CNT_STYLE != CNT_TREE && CNT_STYLE != CNT_CHAIN) begin : g_bad_style
      $error("hdlock_unit: unknown CNT_STYLE");
   end

   logic flip_hit;
   logic rest_hit;

   hdlock_path #(.W(W), .HD(HD), .CNT_STYLE(CNT_STYLE)) u_flip (
      .slice_i (slice_i),
      .key_i   (FIX_KEY),
      .hit_o   (flip_hit)
   );

   hdlock_path #(.W(W), .HD(HD), .CNT_STYLE(CNT_STYLE)) u_rest (
      .slice_i (slice_i),
      .key_i   (key_i),
      .hit_o   (rest_hit)
   );

   assign prot_o = func_i ^ flip_hit ^ rest_hit;

   always_comb begin
      // R4
      transparent_chk: assert (key_i != FIX_KEY || prot_o == func_i)
         else $error("correct key did not restore output");
   end

   if (HD == 0) begin : g_eq_chk
      always_comb begin
         // R6
         eq_flip_chk: assert (!flip_hit || slice_i == FIX_KEY)
            else $error("equality flip fired without exact match");
      end
   end

endmodule

// File: tb/hdlock_unit_tb.sv
module hdlock_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int HD = 2;
   localparam logic [7:0] FK = 8'hB2;

   // vector: slice, key, func, expected prot
   localparam int NV = 7;
   localparam logic [17:0] VEC [NV] = '{
      {8'hB2, 8'hB2, 1'b1, 1'b1},
      {8'hB3, 8'hB2, 1'b0, 1'b0},
      {8'hB1, 8'hB2, 1'b1, 1'b1},
      {8'hB1, 8'h00, 1'b0, 1'b1},
      {8'h03, 8'h00, 1'b1, 1'b0},
      {8'hB1, 8'h30, 1'b0, 1'b0},
      {8'hFF, 8'h00, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [W-1:0] slice, key;
   logic func;
   logic prot, prot_eq, prot_ch;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   hdlock_unit #(.W(W), .HD(HD), .CNT_STYLE(0), .FIX_KEY(FK)) u_dut (
      .slice_i(slice), .key_i(key), .func_i(func), .prot_o(prot));

   hdlock_unit #(.W(W), .HD(0), .CNT_STYLE(0), .FIX_KEY(FK)) u_eq (
      .slice_i(slice), .key_i(key), .func_i(func), .prot_o(prot_eq));

   hdlock_unit #(.W(W), .HD(HD), .CNT_STYLE(1), .FIX_KEY(FK)) u_ch (
      .slice_i(slice), .key_i(key), .func_i(func), .prot_o(prot_ch));

   function automatic int ones(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic logic model(input logic [7:0] s, input logic [7:0] k,
                                  input logic f, input int d);
      return f ^ (ones(s ^ FK) == d) ^ (ones(s ^ k) == d);
   endfunction

   task automatic drive(input logic [7:0] s, input logic [7:0] k, input logic f);
      @(posedge clk);
      slice = s; key = k; func = f;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s slice=%h key=%h func=%b act=%b exp=%b",
                  req, slice, key, func, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s key=%h act=%0d exp=%0d", req, key, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      slice = '0; key = '0; func = 1'b0;

      // idle state: all-zero inputs, distance to FK is 4, to key 0 -> no hits (R3)
      @(negedge clk);
      check("R3 idle", prot, 1'b0);

      // table of hand-computed vectors (R1 R2 R3)
      for (int v = 0; v < NV; v++) begin
         drive(VEC[v][17:10], VEC[v][9:2], VEC[v][1]);
         check("R3 table", prot, VEC[v][0]);
      end

      // correct key: fully transparent (R4)
      for (int f = 0; f < 2; f++) begin
         for (int s = 0; s < 256; s++) begin
            drive(8'(s), FK, f[0]);
            check("R4 correct key", prot, f[0]);
         end
      end

      // wrong keys: per pattern and total inverted count (R1 R2 R5 R8)
      begin
         logic [7:0] wk [5] = '{8'h00, 8'hB3, 8'hB1, 8'h4D, 8'hFF};
         foreach (wk[n]) begin
            int got = 0;
            int want = 0;
            for (int s = 0; s < 256; s++) begin
               logic e;
               drive(8'(s), wk[n], 1'b0);
               e = model(8'(s), wk[n], 1'b0, HD);
               check("R1 R2 wrong key", prot, e);
               check("R8 chain counter", prot_ch, e);
               if (prot) got++;
               if ((ones(8'(s) ^ FK) == HD) != (ones(8'(s) ^ wk[n]) == HD)) want++;
            end
            check_int("R5 corrupted count", got, want);
         end
      end

      // equality variant, HD = 0 (R6)
      begin
         int got = 0;
         for (int s = 0; s < 256; s++) begin
            drive(8'(s), 8'h5C, 1'b1);
            check("R6 equality", prot_eq, 1'b1 ^ (8'(s) == FK) ^ (8'(s) == 8'h5C));
            if (prot_eq != 1'b1) got++;
         end
         check_int("R6 equality count", got, 2);
      end

      // full-distance corner: slice is the complement of key (R7)
      drive(~FK, FK, 1'b0);
      check("R7 max distance", prot, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule